// File: doc/BRIEF.md
# Sustained-Precondition Window Checker

This block is a synthesizable run-time monitor for two single-bit signals that share a clock. The qualifier signal is driven independently and may go high for reasons that have nothing to do with the trigger. The checker therefore never starts timing from the qualifier's own rising edge. It keeps a running count of how many consecutive clocks the qualifier has been high. When the trigger rises, it looks back at that count and decides whether the precondition was held long enough, but not too long.

A trigger edge is judged good when two things are true. The qualifier must still be high in the trigger cycle. The number of earlier consecutive high cycles, not counting the trigger cycle, must fall inside an inclusive window from `LO` to `HI`. The default window is 3 to 4.

Each judged edge produces a one-cycle pass or fail pulse. Two saturating event counters total the outcomes. The current run length is also exported, so a surrounding test environment or a debug path can see it.

Top module: `qual_window_checker`

## Requirements
- R1: A check is made only at a clock edge where `trig_i` is 1 and the previously registered trigger sample is 0. A trigger held high for further cycles produces no new pulse and leaves both counters unchanged.
- R2: `run_len_o` becomes 0 at any edge where `rst` is 1 or `qual_i` is 0. At any other edge it increases by one. It therefore equals the number of consecutive edges at which `qual_i` was sampled high.
- R3: `run_len_o` is `RUN_W = $clog2(HI+2)` bits wide. It saturates at `2**RUN_W-1` instead of wrapping. With the defaults, a qualifier that is high for 9 cycles reads 7.
- R4: A checked edge passes only if `qual_i` is 1 at that edge and the run length just before it lies in `[LO, HI]`. Otherwise it fails. With the defaults, a qualifier that rises 3 or 4 cycles before the trigger passes, and one that rises 0, 1, 2 or 5 or more cycles before it fails.
- R5: `pass_o` and `fail_o` rise for exactly one cycle, in the cycle after the edge that sampled the trigger rise. They are never 1 together.
- R6: While `rst` is 1, and in the cycle after it is released, `pass_o`, `fail_o`, `run_len_o` and both counters are 0. Reset is synchronous and active high.
- R7: The stored trigger sample resets to 0. A trigger that is already 1 when reset is released is checked at the first edge after release. With `LO` > 0 that check is a fail.
- R8: `pass_cnt_o` and `fail_cnt_o` are `CNT_W` bits wide (default 32). Each increases by one in the same cycle that its pulse is high. Each holds at `2**CNT_W-1` once it gets there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qual_i | input | 1 | Qualifier being tracked |
| trig_i | input | 1 | Trigger whose rising edge starts a check |
| pass_o | output | 1 | One-cycle pulse for a good trigger edge |
| fail_o | output | 1 | One-cycle pulse for a bad trigger edge |
| pass_cnt_o | output | CNT_W | Saturating count of passes |
| fail_cnt_o | output | CNT_W | Saturating count of fails |
| run_len_o | output | RUN_W | Current saturating qualifier run length |

## Verification
The hardest states to reach are the two counter saturation points, since 32-bit counters cannot be filled in a short run. The bench builds the checker with a 5-bit counter width and drives more than 31 triggers of each outcome, so both counters are seen to stop at their ceiling. The run-length ceiling is reached by sweeping the qualifier's lead time past the counter's top value. The check at reset release is reached by holding the trigger high through reset.

// File: rtl/wc_pkg.sv
package wc_pkg;

    typedef struct packed {
        logic pass;
        logic fail;
    } verdict_t;

    localparam int NUM_OUTCOMES = 2;
    localparam int IDX_PASS     = 0;
    localparam int IDX_FAIL     = 1;

    // True when a run length sits inside the inclusive window.
    function automatic logic in_window(input int unsigned run,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (run >= lo) && (run <= hi);
    endfunction

endpackage

// File: rtl/wc_run_tracker.sv
module wc_run_tracker #(
    parameter int RUN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qual_i,
    output logic [RUN_W-1:0] run_q
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || !qual_i) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    assert_run_clears_R2: assert property (@(posedge clk) disable iff (rst)
        !qual_i |=> (run_q == '0));

    assert_run_counts_R2: assert property (@(posedge clk) disable iff (rst)
        (qual_i && run_q != RUN_MAX) |=> (run_q == $past(run_q) + RUN_W'(1)));

    assert_run_holds_max_R3: assert property (@(posedge clk) disable iff (rst)
        (qual_i && run_q == RUN_MAX) |=> (run_q == RUN_MAX));

endmodule

// File: rtl/wc_trig_edge.sv
module wc_trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= trig_i;
    end

    assign rise_o = trig_i && !prev_q;

    assert_no_rise_when_held_R1: assert property (@(posedge clk) disable iff (rst)
        trig_i |=> !rise_o || !trig_i);

endmodule

// File: rtl/wc_verdict.sv
module wc_verdict #(
    parameter int LO    = 3,
    parameter int HI    = 4,
    parameter int RUN_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rise_i,
    input  logic                qual_i,
    input  logic [RUN_W-1:0]    run_i,
    output wc_pkg::verdict_t    next_o,
    output wc_pkg::verdict_t    cur_o
);
    import wc_pkg::*;

    logic ok;

    always_comb begin
        ok          = qual_i && in_window(32'(run_i), LO, HI);
        next_o.pass = rise_i && ok;
        next_o.fail = rise_i && !ok;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_o <= '0;
        else     cur_o <= next_o;
    end

    assert_never_both_R5: assert property (@(posedge clk) disable iff (rst)
        !(cur_o.pass && cur_o.fail));

    assert_quiet_after_reset_R6: assert property (@(posedge clk)
        rst |=> (cur_o == '0));

endmodule

// File: rtl/wc_sat_counter.sv
module wc_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                           cnt_q <= '0;
        else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        (inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_count_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!inc_i || cnt_q == CNT_MAX) |=> $stable(cnt_q));

endmodule

// File: rtl/qual_window_checker.sv
module qual_window_checker #(
    parameter  int LO    = 3,
    parameter  int HI    = 4,
    parameter  int CNT_W = 32,
    localparam int RUN_W = $clog2(HI + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qual_i,
    input  logic             trig_i,
    output logic             pass_o,
    output logic             fail_o,
    output logic [CNT_W-1:0] pass_cnt_o,
    output logic [CNT_W-1:0] fail_cnt_o,
    output logic [RUN_W-1:0] run_len_o
);
    import wc_pkg::*;

    initial begin
        if (LO > HI || LO < 0) $error("qual_window_checker: window bounds out of order");
    end

    logic             rise;
    logic [RUN_W-1:0] run;
    verdict_t         v_next;
    verdict_t         v_cur;
    logic [CNT_W-1:0] counts [NUM_OUTCOMES];
    logic             incs   [NUM_OUTCOMES];

    wc_run_tracker #(.RUN_W(RUN_W)) u_run (
        .clk(clk), .rst(rst), .qual_i(qual_i), .run_q(run)
    );

    wc_trig_edge u_edge (
        .clk(clk), .rst(rst), .trig_i(trig_i), .rise_o(rise)
    );

    wc_verdict #(.LO(LO), .HI(HI), .RUN_W(RUN_W)) u_verdict (
        .clk(clk), .rst(rst), .rise_i(rise), .qual_i(qual_i),
        .run_i(run), .next_o(v_next), .cur_o(v_cur)
    );

    assign incs[IDX_PASS] = v_next.pass;
    assign incs[IDX_FAIL] = v_next.fail;

    for (genvar g = 0; g < NUM_OUTCOMES; g++) begin : g_cnt
        wc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst(rst), .inc_i(incs[g]), .cnt_q(counts[g])
        );
    end

    assign pass_o     = v_cur.pass;
    assign fail_o     = v_cur.fail;
    assign pass_cnt_o = counts[IDX_PASS];
    assign fail_cnt_o = counts[IDX_FAIL];
    assign run_len_o  = run;

    assert_edge_gives_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        rise |=> (pass_o ^ fail_o));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        (pass_o || fail_o) |=> !(pass_o || fail_o));

endmodule

// File: tb/sim_qual_window_checker.sv
`timescale 1ns/1ps
module sim_qual_window_checker;
    localparam int LO    = 3;
    localparam int HI    = 4;
    localparam int CNT_W = 5;
    localparam int RUN_W = $clog2(HI + 2);
    localparam int RMAX  = (1 << RUN_W) - 1;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic qual = 1'b0;
    logic trig = 1'b0;
    logic pass_o, fail_o;
    logic [CNT_W-1:0] pass_cnt, fail_cnt;
    logic [RUN_W-1:0] run_len;

    int errors = 0;
    int checks = 0;
    int exp_pass = 0;
    int exp_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    qual_window_checker #(.LO(LO), .HI(HI), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .qual_i(qual), .trig_i(trig),
        .pass_o(pass_o), .fail_o(fail_o),
        .pass_cnt_o(pass_cnt), .fail_cnt_o(fail_cnt), .run_len_o(run_len)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_counts(input string req);
        chk({req, " pass count"}, pass_cnt, exp_pass);
        chk({req, " fail count"}, fail_cnt, exp_fail);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One trial: qualifier high for k cycles, then trigger rises with qualifier q.
    task automatic trial(input int k, input bit q, input bit check_run);
        bit good;
        trig = 0; qual = 0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < k; i++) begin
            qual = 1;
            @(negedge clk);
        end
        if (check_run) chk("R2/R3 run length", run_len, (k < RMAX) ? k : RMAX);
        good = q && ((k < RMAX ? k : RMAX) >= LO) && ((k < RMAX ? k : RMAX) <= HI);
        trig = 1; qual = q;
        @(negedge clk);
        if (good) exp_pass = (exp_pass < CMAX) ? exp_pass + 1 : CMAX;
        else      exp_fail = (exp_fail < CMAX) ? exp_fail + 1 : CMAX;
        if (check_run) begin
            chk("R4 pass", pass_o, good);
            chk("R4 fail", fail_o, !good);
            chk_counts("R8");
        end
        trig = 0; qual = 0;
        @(negedge clk);
        if (check_run) begin
            chk("R5 pulse ends", pass_o | fail_o, 0);
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        // R7: trigger already high through reset
        trig = 1; qual = 0; rst = 1;
        repeat (3) @(negedge clk);
        chk("R6 pass in reset", pass_o, 0);
        chk("R6 fail in reset", fail_o, 0);
        chk("R6 run in reset", run_len, 0);
        chk_counts("R6");
        rst = 0;
        @(negedge clk);
        exp_fail = 1;
        chk("R7 fail at release", fail_o, 1);
        chk("R7 pass at release", pass_o, 0);
        chk_counts("R7");
        // R1: held trigger, varied qualifier, no new checks
        for (int i = 0; i < 4; i++) begin
            qual = i[0];
            @(negedge clk);
            chk("R1 held trigger no pulse", pass_o | fail_o, 0);
            chk_counts("R1");
        end
        // R2/R3/R4 sweep of lead time and trigger-cycle qualifier
        for (int rep = 0; rep < 2; rep++)
            for (int k = 0; k <= RMAX + 2; k++)
                for (int q = 0; q < 2; q++)
                    trial(k, q[0], 1'b1);
        // R8 saturation of both counters
        for (int i = 0; i < CMAX + 3; i++) trial(LO, 1'b1, 1'b0);
        chk_counts("R8 pass saturated");
        for (int i = 0; i < CMAX + 3; i++) trial(0, 1'b0, 1'b0);
        chk_counts("R8 fail saturated");
        trial(HI, 1'b1, 1'b1);
        // R6: reset mid-run clears everything
        qual = 1; rst = 1;
        @(negedge clk);
        rst = 0; qual = 0;
        exp_pass = 0; exp_fail = 0;
        chk("R6 run after reset", run_len, 0);
        chk_counts("R6 after reset");
        summary();
    end
endmodule